// File: doc/BRIEF.md
# Low-Power Mode Domain Controller

This block turns a 4-bit power-mode code written by software into clock-enable outputs for four clock domains. The domains are the processor core, the peripheral bus, the PLL, and the oscillator/timer domain. The modes form graded levels. Each deeper level gates a larger nested set of domains, starting at the core and working outward toward the oscillator.

While the block is in any low-power level, any of four interrupt lines wakes it. The wake event forces the mode register back to the active code. The core clock then stays held off while a start-up counter runs down. The counter is loaded from a per-level, per-divider delay. The shallow levels (pause, nap) use a short delay that doubles with each step of the 3-bit clock divider. The deep levels (sleep, stop) use a longer delay that grows linearly with the divider. A ready flag reports that the start-up delay has elapsed. The PLL lock time and the oscillator start-up time are modelled by this counted delay alone.

Top module: `lpm_domain_ctrl`

## Requirements
- R1: After reset the mode register holds the active code 4'b1111, all four domain enables are 1, and `ready` is 1.
- R2: Writing 4'b1110 (pause) on `wr_data` with `wr_en` high gates only the core. After that clock edge, `core_en`=0 and `periph_en`=`pll_en`=`osc_en`=1.
- R3: Writing 4'b1100 (nap) gates the core and peripheral domains. The PLL and oscillator domains stay enabled.
- R4: Writing 4'b1000 (sleep) leaves only `osc_en` at 1.
- R5: Writing 4'b0000 (stop) drives all four enables to 0.
- R6: Any written code other than 1111, 1110, 1100, 1000 and 0000 acts as active mode. All four enables are 1, and `ready` is unchanged.
- R7: In any low-power level, a 1 on any single bit of `irq` at a clock edge restores the active code. From that edge on, `periph_en`, `pll_en` and `osc_en` are 1.
- R8: A wake from pause or nap holds `ready` and `core_en` at 0 for exactly SHORT_BASE << `clk_div` clock edges after the wake edge. With the defaults this is 3 << `clk_div`. Both outputs then rise together.
- R9: A wake from sleep or stop holds `ready` and `core_en` at 0 for exactly LONG_BASE + LONG_STEP * `clk_div` edges after the wake edge. With the defaults this is 400 + 60 * `clk_div`.
- R10: In active mode, with no write, `irq` activity has no effect. The enables and `ready` stay at 1.
- R11: When a wake and a write occur at the same edge, the wake takes priority. The mode becomes active, and the delay is taken from the level held before that edge.
- R12: The delay uses the `clk_div` value sampled at the wake edge. A change of `clk_div` during the countdown does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | 4 | Mode code to store |
| irq | input | 4 | Wake request lines, one per bit, active high |
| clk_div | input | 3 | Current clock-divider setting, selects the wake delay |
| core_en | output | 1 | Processor core clock enable |
| periph_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator/timer domain enable |
| ready | output | 1 | Start-up delay finished |

## Verification
The properties take `irq`, `wr_en` and `wr_data` as already synchronous to `clk` and stable around each rising edge. They also assume the wake delay is never zero, so every wake produces at least one cycle with `ready` low. The stimulus keeps within these limits: every input changes only at a falling edge, and the delay parameters stay at values of one or more. `clk_div` is moved during a countdown on purpose, to show that the sampled value is kept.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int NUM_DOM = 4;

  localparam logic [3:0] MODE_ACTIVE = 4'b1111;
  localparam logic [3:0] MODE_PAUSE  = 4'b1110;
  localparam logic [3:0] MODE_NAP    = 4'b1100;
  localparam logic [3:0] MODE_SLEEP  = 4'b1000;
  localparam logic [3:0] MODE_STOP   = 4'b0000;

  // Ordinal = number of domains gated (nesting depth)
  typedef enum logic [2:0] {
    LVL_ACTIVE = 3'd0,
    LVL_PAUSE  = 3'd1,
    LVL_NAP    = 3'd2,
    LVL_SLEEP  = 3'd3,
    LVL_STOP   = 3'd4
  } lvl_e;

  function automatic lvl_e decode_mode(input logic [3:0] code);
    lvl_e lv;
    case (code)
      MODE_PAUSE: lv = LVL_PAUSE;
      MODE_NAP:   lv = LVL_NAP;
      MODE_SLEEP: lv = LVL_SLEEP;
      MODE_STOP:  lv = LVL_STOP;
      default:    lv = LVL_ACTIVE;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
  import lpm_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_data,
  input  logic [IRQ_W-1:0] irq,
  output lvl_e             level,
  output logic             wake
);
  logic [3:0] mode_q;
  logic [3:0] mode_d;
  logic       mode_en;

  assign level = decode_mode(mode_q);
  assign wake  = (|irq) && (level != LVL_ACTIVE);

  always_comb begin
    mode_d  = mode_q;
    mode_en = 1'b0;
    if (wake) begin
      mode_d  = MODE_ACTIVE;
      mode_en = 1'b1;
    end else if (wr_en) begin
      mode_d  = wr_data;
      mode_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_ACTIVE;
    else if (mode_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer
  import lpm_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int SHORT_BASE = 3,
  parameter int LONG_BASE  = 400,
  parameter int LONG_STEP  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  lvl_e             level,
  input  logic [DIV_W-1:0] clk_div,
  output logic             ready
);
  localparam int DIV_MAX   = (1 << DIV_W) - 1;
  localparam int SHORT_MAX = SHORT_BASE << DIV_MAX;
  localparam int LONG_MAX  = LONG_BASE + LONG_STEP * DIV_MAX;
  localparam int DLY_MAX   = (SHORT_MAX > LONG_MAX) ? SHORT_MAX : LONG_MAX;
  localparam int CNT_W     = $clog2(DLY_MAX + 1);

  function automatic logic [CNT_W-1:0] wake_delay(input lvl_e lv,
                                                  input logic [DIV_W-1:0] dv);
    int t;
    if (lv == LVL_PAUSE || lv == LVL_NAP) t = SHORT_BASE << dv;
    else                                  t = LONG_BASE + LONG_STEP * int'(dv);
    return t[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (wake) begin
      cnt_d  = wake_delay(level, clk_div);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/lpm_domain_gate.sv
module lpm_domain_gate
  import lpm_pkg::*;
(
  input  lvl_e               level,
  input  logic               ready,
  output logic [NUM_DOM-1:0] dom_en
);
  // Domain d stays on while the level's depth does not exceed d.
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (d == 0) begin : g_core
      assign dom_en[d] = (level <= lvl_e'(d)) && ready;
    end else begin : g_outer
      assign dom_en[d] = (level <= lvl_e'(d));
    end
  end
endmodule

// File: rtl/lpm_domain_ctrl.sv
module lpm_domain_ctrl
  import lpm_pkg::*;
#(
  parameter int IRQ_W      = 4,
  parameter int DIV_W      = 3,
  parameter int SHORT_BASE = 3,
  parameter int LONG_BASE  = 400,
  parameter int LONG_STEP  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_data,
  input  logic [IRQ_W-1:0] irq,
  input  logic [DIV_W-1:0] clk_div,
  output logic             core_en,
  output logic             periph_en,
  output logic             pll_en,
  output logic             osc_en,
  output logic             ready
);
  logic               rst_sync_n;
  lvl_e               level;
  logic               wake;
  logic [NUM_DOM-1:0] dom_en;

  lpm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpm_mode_reg #(.IRQ_W(IRQ_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .irq     (irq),
    .level   (level),
    .wake    (wake)
  );

  lpm_wake_timer #(
    .DIV_W      (DIV_W),
    .SHORT_BASE (SHORT_BASE),
    .LONG_BASE  (LONG_BASE),
    .LONG_STEP  (LONG_STEP)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wake    (wake),
    .level   (level),
    .clk_div (clk_div),
    .ready   (ready)
  );

  lpm_domain_gate u_gate (
    .level  (level),
    .ready  (ready),
    .dom_en (dom_en)
  );

  assign core_en   = dom_en[0];
  assign periph_en = dom_en[1];
  assign pll_en    = dom_en[2];
  assign osc_en    = dom_en[3];
endmodule

// File: rtl/lpm_domain_ctrl_chk.sv
module lpm_domain_ctrl_chk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IRQ_W-1:0] irq,
  input logic             core_en,
  input logic             periph_en,
  input logic             pll_en,
  input logic             osc_en,
  input logic             ready
);
  AST_CORE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (ready && periph_en)); // R8

  AST_PERIPH_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en |-> pll_en); // R3

  AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> osc_en); // R4

  AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!pll_en && !periph_en && !core_en)); // R5

  AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq) && !core_en && ready) |=> (periph_en && pll_en && osc_en && !ready)); // R7

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !wr_en) |=> core_en); // R10
endmodule

bind lpm_domain_ctrl lpm_domain_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .irq       (irq),
  .core_en   (core_en),
  .periph_en (periph_en),
  .pll_en    (pll_en),
  .osc_en    (osc_en),
  .ready     (ready)
);

// File: tb/sim_lpm_domain_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_domain_ctrl;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_data;
  logic [3:0] irq;
  logic [2:0] clk_div;
  logic       core_en, periph_en, pll_en, osc_en, ready;

  int tests  = 0;
  int fails  = 0;
  bit done   = 0;

  lpm_domain_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .irq (irq), .clk_div (clk_div), .core_en (core_en),
    .periph_en (periph_en), .pll_en (pll_en), .osc_en (osc_en), .ready (ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int doms();
    return int'({core_en, periph_en, pll_en, osc_en});
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [3:0] code);
    @(negedge clk);
    wr_en = 1'b1; wr_data = code;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Wake with given line mask; expect delay n edges. Optional: write at same
  // edge (R11) or divider change after wake (R12).
  task automatic wake_timed(input string req, input logic [3:0] mask,
                            input logic [2:0] dv, input int exp_n,
                            input bit with_wr, input bit move_div);
    int n;
    @(negedge clk);
    clk_div = dv;
    irq = mask;
    if (with_wr) begin wr_en = 1'b1; wr_data = 4'b0000; end
    @(posedge clk); #1;
    irq = 4'b0; wr_en = 1'b0;
    if (move_div) clk_div = ~dv;
    chk({req, " ready low after wake"}, int'(ready), 0);
    chk({req, " outer domains on after wake"}, doms(), 4'b0111);
    n = 0;
    while (!ready && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
    chk({req, " wake delay"}, n, exp_n);
    chk({req, " core on when ready"}, doms(), 4'b1111);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 4'b0; irq = 4'b0; clk_div = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 enables", doms(), 4'b1111);
    chk("R1 ready", int'(ready), 1);
  endtask

  task automatic t_levels();
    write_mode(4'b1110); chk("R2 pause", doms(), 4'b0111);
    write_mode(4'b1100); chk("R3 nap", doms(), 4'b0011);
    write_mode(4'b1000); chk("R4 sleep", doms(), 4'b0001);
    write_mode(4'b0000); chk("R5 stop", doms(), 4'b0000);
    write_mode(4'b1111); chk("R1 active write", doms(), 4'b1111);
  endtask

  task automatic t_illegal();
    logic [3:0] codes [3] = '{4'b1010, 4'b0111, 4'b1101};
    for (int i = 0; i < 3; i++) begin
      write_mode(4'b1000);
      write_mode(codes[i]);
      chk("R6 illegal acts active", doms(), 4'b1111);
      chk("R6 ready unchanged", int'(ready), 1);
    end
  endtask

  task automatic t_each_line();
    for (int i = 0; i < 4; i++) begin
      write_mode(4'b0000);
      wake_timed("R7 line wakes stop", 4'b0001 << i, 3'd0, 400, 1'b0, 1'b0);
    end
  endtask

  task automatic t_short();
    write_mode(4'b1110); wake_timed("R8 pause div0", 4'b0010, 3'd0, 3, 1'b0, 1'b0);
    write_mode(4'b1100); wake_timed("R8 nap div7", 4'b0100, 3'd7, 384, 1'b0, 1'b0);
    write_mode(4'b1100); wake_timed("R8 nap div2", 4'b1000, 3'd2, 12, 1'b0, 1'b0);
  endtask

  task automatic t_long();
    write_mode(4'b1000); wake_timed("R9 sleep div0", 4'b0001, 3'd0, 400, 1'b0, 1'b0);
    write_mode(4'b0000); wake_timed("R9 stop div7", 4'b0001, 3'd7, 820, 1'b0, 1'b0);
    write_mode(4'b0000); wake_timed("R9 stop div3", 4'b1000, 3'd3, 580, 1'b0, 1'b0);
  endtask

  task automatic t_active_irq();
    @(negedge clk);
    irq = 4'b1111;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R10 irq ignored enables", doms(), 4'b1111);
      chk("R10 irq ignored ready", int'(ready), 1);
    end
    irq = 4'b0;
  endtask

  task automatic t_collide();
    write_mode(4'b1100);
    wake_timed("R11 wake beats write", 4'b0100, 3'd1, 6, 1'b1, 1'b0);
  endtask

  task automatic t_div_move();
    write_mode(4'b1110);
    wake_timed("R12 div sampled at wake", 4'b0001, 3'd4, 48, 1'b0, 1'b1);
    write_mode(4'b1000);
    wake_timed("R12 div sampled long", 4'b0010, 3'd1, 460, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_levels();
    t_illegal();
    t_each_line();
    t_short();
    t_long();
    t_active_irq();
    t_collide();
    t_div_move();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule